// File: doc/BRIEF.md
# Cipher Unit Context Register Bank

This block is the host-side register bank of a stream-cipher execution unit that runs in a confidentiality mode or an integrity mode. It holds a 64-bit integrity nonce ("fresh") value, six 64-bit context words that software saves and reloads when a message is interrupted, and a 128-bit confidentiality key stored as two write-only 64-bit halves. The cipher core reads the key, the context words and the mode-gated nonce straight from dedicated output buses. It also drives a busy line that marks when a message is being processed.

The bank enforces the unit's access rules. Any write to context or key while the core is busy is rejected and raises a sticky context-error flag. The bank also tracks restore order: once a key half has been loaded, a later context write is refused until processing has started. Reading a key half, or touching an unmapped or misaligned offset, raises a sticky address-error flag and returns zero. Software clears the flags by writing ones to a status word. A soft reset or an initialize command clears the context words and flags, and the hard reset clears everything.

The map is word-addressed on 8-byte boundaries. Byte offset 0x00 is the nonce, 0x08 to 0x30 are context words 0 to 5, 0x38 is the key high half, 0x40 is the key low half and 0x48 is the status word.

Top module: `ck_ctx_regbank`

## Requirements
- R1: After the hard reset (rst_n low), every context word, the nonce, both key halves and both error flags read or drive zero.
- R2: With busy low and no key loaded since the last processing start, a write to context offset 0x08+8*i (i = 0..5) stores wdata, and a read of that offset returns it in the same cycle rd_en is high.
- R3: A context write while busy is high leaves all context words unchanged and sets ctx_err (status bit 0) in the next cycle.
- R4: A key write while busy is high leaves key_out unchanged and sets ctx_err in the next cycle.
- R5: A read of either key offset (0x38, 0x40) returns zero on rdata and sets addr_err (status bit 1) in the next cycle.
- R6: A one-cycle init_cmd clears all context words and both flags but keeps the key and nonce. A one-cycle soft_rst additionally clears the key and the nonce.
- R7: The nonce at 0x00 is read/write. core_fresh equals the nonce when mode_f9 is 1 and is zero when mode_f9 is 0.
- R8: After an accepted key write, a context write is rejected and sets ctx_err until busy rises. After busy has risen, context writes are accepted again.
- R9: Error flags are sticky. Writing the status word at 0x48 with a 1 in a bit position clears that flag, and a 0 leaves it unchanged. Reading status returns {addr_err, ctx_err} in bits [1:0].
- R10: A read or write at a misaligned offset (addr[2:0] not zero) or at an offset above 0x48 sets addr_err, reads return zero, and writes change no register.
- R11: Accepted key writes place the high half (key bytes 1 to 8) in key_out[127:64] and the low half (bytes 9 to 16) in key_out[63:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset pulse: clears context, flags, key, nonce |
| init_cmd | input | 1 | Initialize pulse: clears context and flags |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 8 | Host byte offset |
| wdata | input | 64 | Host write data |
| rdata | output | 64 | Host read data, combinational while rd_en is high |
| busy | input | 1 | Core is processing a message |
| mode_f9 | input | 1 | 1 selects the integrity mode, 0 the confidentiality mode |
| ctx_err | output | 1 | Sticky context-error flag |
| addr_err | output | 1 | Sticky address-error flag |
| key_out | output | 128 | Confidentiality key to the core |
| core_fresh | output | 64 | Nonce to the core, zero in confidentiality mode |
| ctx_flat | output | 384 | Six context words to the core, word i in bits [64*i+63:64*i] |

## Verification
The bench targets the restore-order tracker. A design that never rearms it, or never clears it on busy rising, would either let a late context write through or reject a legitimate one. A read-back of the context word after each case exposes both faults. Busy-time writes to context and key are read back, or observed on key_out, to catch a design that flags the error but still stores the data. Key reads and misaligned or out-of-range offsets are checked for a zero return and the address flag, which catches a design that leaks the key or decodes only the upper address bits. The tests also write status values with mixed bits, so a flag clear that wipes both flags, or a flag that is not sticky, shows up.

// File: rtl/ck_pkg.sv
// Package ck_pkg: shared types for the cipher context register bank.
// Assumes a byte-offset bus decoded on 8-byte words.
package ck_pkg;
    // Kinds of target an access can land on
    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_FRESH  = 3'd1,
        SEL_CTX    = 3'd2,
        SEL_KEY_HI = 3'd3,
        SEL_KEY_LO = 3'd4,
        SEL_STATUS = 3'd5
    } sel_e;

    // Status word layout
    localparam int STATUS_W   = 2;
    localparam int ST_CTX_BIT = 0;
    localparam int ST_ADR_BIT = 1;
endpackage

// File: rtl/ck_addr_decode.sv
// ck_addr_decode: maps a byte offset to a target kind and a one-hot
// context select. Assumes offsets are word aligned to 8 bytes; any other
// offset, or a word past the status word, decodes to SEL_NONE.
module ck_addr_decode
    import ck_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int N_CTX  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              kind,
    output logic [N_CTX-1:0]  ctx_hot
);
    localparam int WORD_W = ADDR_W - 3;
    localparam logic [WORD_W-1:0] W_FRESH  = '0;
    localparam logic [WORD_W-1:0] W_KEY_HI = WORD_W'(N_CTX + 1);
    localparam logic [WORD_W-1:0] W_KEY_LO = WORD_W'(N_CTX + 2);
    localparam logic [WORD_W-1:0] W_STATUS = WORD_W'(N_CTX + 3);

    logic [WORD_W-1:0] word;
    logic              aligned;

    assign word    = addr[ADDR_W-1:3];
    assign aligned = (addr[2:0] == 3'b000);

    // One comparator per context word
    for (genvar g = 0; g < N_CTX; g++) begin : g_ctx_hit
        assign ctx_hot[g] = aligned && (word == WORD_W'(g + 1));
    end

    // Classify the access
    always_comb begin
        kind = SEL_NONE;
        if (aligned) begin
            if (word == W_FRESH)       kind = SEL_FRESH;
            else if (|ctx_hot)         kind = SEL_CTX;
            else if (word == W_KEY_HI) kind = SEL_KEY_HI;
            else if (word == W_KEY_LO) kind = SEL_KEY_LO;
            else if (word == W_STATUS) kind = SEL_STATUS;
        end
    end
endmodule

// File: rtl/ck_ctx_store.sv
// ck_ctx_store: N_CTX host-visible context words. A word loads only when
// the top has already accepted the write; clr zeroes every word.
module ck_ctx_store #(
    parameter int DATA_W = 64,
    parameter int N_CTX  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_ok,
    input  logic [N_CTX-1:0]        wr_hot,
    input  logic [DATA_W-1:0]       wdata,
    output logic [N_CTX*DATA_W-1:0] ctx_flat
);
    for (genvar g = 0; g < N_CTX; g++) begin : g_word
        logic [DATA_W-1:0] word_q;

        // Hold one context word
        always_ff @(posedge clk) begin
            if (!rst_n || clr)              word_q <= '0;
            else if (wr_ok && wr_hot[g])    word_q <= wdata;
        end

        assign ctx_flat[g*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/ck_key_store.sv
// ck_key_store: the two key halves plus the restore-order tracker.
// key_loaded is set by any accepted key write and cleared when busy rises
// or on clr_track; clr_key zeroes both halves.
module ck_key_store #(
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_key,
    input  logic                clr_track,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                busy,
    output logic [2*DATA_W-1:0] key_out,
    output logic                key_loaded
);
    logic [DATA_W-1:0] hi_q, lo_q;
    logic              busy_q;
    logic              busy_rise;

    assign busy_rise = busy && !busy_q;

    // Key halves
    always_ff @(posedge clk) begin
        if (!rst_n || clr_key) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (wr_hi) hi_q <= wdata;
            if (wr_lo) lo_q <= wdata;
        end
    end

    // Busy edge history
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Restore-order tracker
    always_ff @(posedge clk) begin
        if (!rst_n || clr_track || busy_rise) key_loaded <= 1'b0;
        else if (wr_hi || wr_lo)              key_loaded <= 1'b1;
    end

    assign key_out = {hi_q, lo_q};
endmodule

// File: rtl/ck_err_status.sv
// ck_err_status: sticky error flags with write-one-to-clear. A set
// request in the same cycle as a clear of that bit wins.
module ck_err_status
    import ck_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [STATUS_W-1:0] set,
    input  logic                w1c_en,
    input  logic [STATUS_W-1:0] w1c_bits,
    output logic [STATUS_W-1:0] flags
);
    logic [STATUS_W-1:0] clr_mask;

    assign clr_mask = w1c_en ? w1c_bits : '0;

    // Flag register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) flags <= '0;
        else               flags <= set | (flags & ~clr_mask);
    end
endmodule

// File: rtl/ck_ctx_regbank.sv
// ck_ctx_regbank: host register bank for a stream-cipher unit. Applies
// the busy lockout, the restore-order rule and the address rules, and
// drives key, context and the mode-gated nonce to the core.
// Assumes rd_en and wr_en share one addr; soft_rst and init_cmd are pulses.
module ck_ctx_regbank
    import ck_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int N_CTX  = 6,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    soft_rst,
    input  logic                    init_cmd,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic                    busy,
    input  logic                    mode_f9,
    output logic                    ctx_err,
    output logic                    addr_err,
    output logic [2*DATA_W-1:0]     key_out,
    output logic [DATA_W-1:0]       core_fresh,
    output logic [N_CTX*DATA_W-1:0] ctx_flat
);
    sel_e                kind;
    logic [N_CTX-1:0]    ctx_hot;
    logic                clr_any;
    logic                ctx_req, key_req;
    logic                ctx_ok, key_ok;
    logic                key_loaded;
    logic [STATUS_W-1:0] err_set, flags;
    logic [DATA_W-1:0]   fresh_q;
    logic [DATA_W-1:0]   ctx_rd;

    ck_addr_decode #(.ADDR_W(ADDR_W), .N_CTX(N_CTX)) u_dec (
        .addr    (addr),
        .kind    (kind),
        .ctx_hot (ctx_hot)
    );

    assign clr_any = soft_rst || init_cmd;
    assign ctx_req = wr_en && (kind == SEL_CTX);
    assign key_req = wr_en && (kind == SEL_KEY_HI || kind == SEL_KEY_LO);
    // R3 / R8: context write needs idle core and no key loaded yet
    assign ctx_ok  = ctx_req && !busy && !key_loaded && !clr_any;
    // R4: key write needs idle core
    assign key_ok  = key_req && !busy && !soft_rst;

    // Error sources
    always_comb begin
        err_set = '0;
        err_set[ST_CTX_BIT] = (ctx_req && (busy || key_loaded)) || (key_req && busy);
        err_set[ST_ADR_BIT] = (rd_en && (kind == SEL_NONE || kind == SEL_KEY_HI ||
                                         kind == SEL_KEY_LO))
                            || (wr_en && kind == SEL_NONE);
    end

    ck_ctx_store #(.DATA_W(DATA_W), .N_CTX(N_CTX)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_any),
        .wr_ok    (ctx_ok),
        .wr_hot   (ctx_hot),
        .wdata    (wdata),
        .ctx_flat (ctx_flat)
    );

    ck_key_store #(.DATA_W(DATA_W)) u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_key    (soft_rst),
        .clr_track  (clr_any),
        .wr_hi      (key_ok && kind == SEL_KEY_HI),
        .wr_lo      (key_ok && kind == SEL_KEY_LO),
        .wdata      (wdata),
        .busy       (busy),
        .key_out    (key_out),
        .key_loaded (key_loaded)
    );

    ck_err_status u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_any),
        .set      (err_set),
        .w1c_en   (wr_en && kind == SEL_STATUS),
        .w1c_bits (wdata[STATUS_W-1:0]),
        .flags    (flags)
    );

    assign ctx_err  = flags[ST_CTX_BIT];
    assign addr_err = flags[ST_ADR_BIT];

    // Nonce register (R7)
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)              fresh_q <= '0;
        else if (wr_en && kind == SEL_FRESH) fresh_q <= wdata;
    end

    assign core_fresh = mode_f9 ? fresh_q : '0;

    // Select the addressed context word for read-back
    always_comb begin
        ctx_rd = '0;
        for (int i = 0; i < N_CTX; i++) begin
            if (ctx_hot[i]) ctx_rd = ctx_rd | ctx_flat[i*DATA_W +: DATA_W];
        end
    end

    // Read mux: key halves and unmapped offsets return zero (R5, R10)
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (kind)
                SEL_FRESH:  rdata = fresh_q;
                SEL_CTX:    rdata = ctx_rd;
                SEL_STATUS: rdata = DATA_W'(flags);
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ck_ctx_regbank_chk.sv
// ck_ctx_regbank_chk: port-level properties of the register bank,
// bound to every instance of ck_ctx_regbank.
module ck_ctx_regbank_chk #(
    parameter int DATA_W = 64,
    parameter int N_CTX  = 6,
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    soft_rst,
    input logic                    init_cmd,
    input logic                    wr_en,
    input logic                    rd_en,
    input logic [ADDR_W-1:0]       addr,
    input logic                    w1c_bit0,
    input logic [DATA_W-1:0]       rdata,
    input logic                    busy,
    input logic                    mode_f9,
    input logic                    ctx_err,
    input logic                    addr_err,
    input logic [2*DATA_W-1:0]     key_out,
    input logic [DATA_W-1:0]       core_fresh,
    input logic [N_CTX*DATA_W-1:0] ctx_flat
);
    localparam int WORD_W = ADDR_W - 3;
    logic [WORD_W-1:0] word;
    logic aligned, hit_ctx, hit_key, hit_st, quiet;

    assign word    = addr[ADDR_W-1:3];
    assign aligned = addr[2:0] == 3'b000;
    assign hit_ctx = aligned && word >= WORD_W'(1) && word <= WORD_W'(N_CTX);
    assign hit_key = aligned && (word == WORD_W'(N_CTX + 1) || word == WORD_W'(N_CTX + 2));
    assign hit_st  = aligned && word == WORD_W'(N_CTX + 3);
    assign quiet   = !soft_rst && !init_cmd;

    assert_busy_ctx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && busy && wr_en && hit_ctx) |=> $stable(ctx_flat));

    assert_busy_ctx_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && busy && wr_en && hit_ctx) |=> ctx_err);

    assert_busy_key_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && busy && wr_en && hit_key) |=> $stable(key_out));

    assert_key_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_key) |-> (rdata == '0));

    assert_key_read_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && rd_en && hit_key) |=> addr_err);

    assert_init_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_cmd |=> (ctx_flat == '0 && !ctx_err && !addr_err));

    assert_f8_hides_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_f9 |-> (core_fresh == '0));

    assert_ctx_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_err && quiet && !(wr_en && hit_st && w1c_bit0)) |=> ctx_err);

    assert_unmapped_rd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !aligned) |-> (rdata == '0));
endmodule

bind ck_ctx_regbank ck_ctx_regbank_chk #(
    .DATA_W(DATA_W), .N_CTX(N_CTX), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .init_cmd   (init_cmd),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .w1c_bit0   (wdata[0]),
    .rdata      (rdata),
    .busy       (busy),
    .mode_f9    (mode_f9),
    .ctx_err    (ctx_err),
    .addr_err   (addr_err),
    .key_out    (key_out),
    .core_fresh (core_fresh),
    .ctx_flat   (ctx_flat)
);

// File: tb/tb_ck_ctx_regbank.sv
// Bench for ck_ctx_regbank: vector table walk, then directed cases.
module tb_ck_ctx_regbank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soft_rst = 1'b0, init_cmd = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [63:0]  wdata = '0;
    logic [63:0]  rdata;
    logic         busy = 1'b0, mode_f9 = 1'b0;
    logic         ctx_err, addr_err;
    logic [127:0] key_out;
    logic [63:0]  core_fresh;
    logic [383:0] ctx_flat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ck_ctx_regbank dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .init_cmd(init_cmd),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .busy(busy), .mode_f9(mode_f9), .ctx_err(ctx_err), .addr_err(addr_err),
        .key_out(key_out), .core_fresh(core_fresh), .ctx_flat(ctx_flat)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic        rd;     // 0 write, 1 read
        logic [7:0]  adr;
        logic [63:0] dat;    // write data or expected read data
        logic        bsy;
        logic [1:0]  flg;    // expected {addr_err, ctx_err} afterwards
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h08, 64'h1111_2222_3333_4444, 1'b0, 2'b00, 4'd2},  // R2
        '{1'b1, 8'h08, 64'h1111_2222_3333_4444, 1'b0, 2'b00, 4'd2},
        '{1'b0, 8'h30, 64'hA5A5_5A5A_0F0F_F0F0, 1'b0, 2'b00, 4'd2},
        '{1'b1, 8'h30, 64'hA5A5_5A5A_0F0F_F0F0, 1'b0, 2'b00, 4'd2},
        '{1'b0, 8'h10, 64'hBAD0_BAD0_BAD0_BAD0, 1'b1, 2'b01, 4'd3},  // R3
        '{1'b1, 8'h10, 64'h0,                   1'b0, 2'b01, 4'd3},
        '{1'b0, 8'h48, 64'h1,                   1'b0, 2'b00, 4'd9},  // R9
        '{1'b0, 8'h38, 64'h0102_0304_0506_0708, 1'b0, 2'b00, 4'd11},
        '{1'b0, 8'h18, 64'h7777_7777_7777_7777, 1'b0, 2'b01, 4'd8},  // R8
        '{1'b1, 8'h18, 64'h0,                   1'b0, 2'b01, 4'd8},
        '{1'b0, 8'h48, 64'h3,                   1'b0, 2'b00, 4'd9},
        '{1'b1, 8'h38, 64'h0,                   1'b0, 2'b10, 4'd5},  // R5
        '{1'b0, 8'h48, 64'h2,                   1'b0, 2'b00, 4'd9},
        '{1'b1, 8'h0C, 64'h0,                   1'b0, 2'b10, 4'd10}, // R10
        '{1'b0, 8'h80, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'b10, 4'd10},
        '{1'b1, 8'h48, 64'h2,                   1'b0, 2'b10, 4'd9},
        '{1'b0, 8'h48, 64'h2,                   1'b0, 2'b00, 4'd9},
        '{1'b0, 8'h00, 64'hDEAD_BEEF_0000_0001, 1'b0, 2'b00, 4'd7},  // R7
        '{1'b1, 8'h00, 64'hDEAD_BEEF_0000_0001, 1'b0, 2'b00, 4'd7}
    };

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input bit is_init);
        @(negedge clk);
        if (is_init) init_cmd = 1'b1; else soft_rst = 1'b1;
        @(negedge clk);
        init_cmd = 1'b0; soft_rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] rd;
        logic [63:0] lo_key;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        mode_f9 = 1'b1;
        @(negedge clk);
        chk(ctx_flat == '0 && key_out == '0 && core_fresh == '0, "R1 regs",
            {key_out[63:0], core_fresh}, '0);
        chk(!ctx_err && !addr_err, "R1 flags", {ctx_err, addr_err}, '0);
        mode_f9 = 1'b0;

        for (int i = 0; i < NV; i++) begin
            busy = VECS[i].bsy;
            if (VECS[i].rd) begin
                bus_rd(VECS[i].adr, rd);
                chk(rd == VECS[i].dat, $sformatf("R%0d vec%0d rdata", VECS[i].req, i),
                    rd, VECS[i].dat);
            end else begin
                bus_wr(VECS[i].adr, VECS[i].dat);
            end
            busy = 1'b0;
            chk({addr_err, ctx_err} == VECS[i].flg,
                $sformatf("R%0d vec%0d flags", VECS[i].req, i),
                {addr_err, ctx_err}, VECS[i].flg);
        end

        // R4: key write while busy is rejected (this busy pulse also clears the tracker)
        busy = 1'b1;
        bus_wr(8'h40, 64'hFFFF_FFFF_FFFF_FFFF);
        busy = 1'b0;
        chk(key_out == {64'h0102_0304_0506_0708, 64'h0}, "R4 key held",
            key_out, {64'h0102_0304_0506_0708, 64'h0});
        chk(ctx_err, "R4 ctx_err", ctx_err, 1);
        bus_wr(8'h48, 64'h1);

        // R8: after busy rose, context writes accepted again
        bus_wr(8'h18, 64'h2222_0000_2222_0000);
        bus_rd(8'h18, rd);
        chk(rd == 64'h2222_0000_2222_0000, "R8 ctx after busy", rd, 64'h2222_0000_2222_0000);
        chk(!ctx_err, "R8 no error", ctx_err, 0);

        // R11: key halves land in order
        lo_key = 64'h090A_0B0C_0D0E_0F10;
        bus_wr(8'h40, lo_key);
        chk(key_out == {64'h0102_0304_0506_0708, lo_key}, "R11 key layout",
            key_out, {64'h0102_0304_0506_0708, lo_key});

        // R7: mode gating of the nonce
        mode_f9 = 1'b1;
        #1 chk(core_fresh == 64'hDEAD_BEEF_0000_0001, "R7 f9 fresh",
               core_fresh, 64'hDEAD_BEEF_0000_0001);
        mode_f9 = 1'b0;
        #1 chk(core_fresh == '0, "R7 f8 fresh", core_fresh, 0);

        // R9: flag stays set while idle; clearing addr bit leaves ctx bit
        bus_wr(8'h08, 64'h5);          // tracker armed by key write: rejected
        bus_rd(8'h40, rd);             // key read: addr_err
        repeat (3) @(negedge clk);
        chk(ctx_err && addr_err, "R9 sticky", {ctx_err, addr_err}, 2'b11);
        bus_wr(8'h48, 64'h2);
        chk(ctx_err && !addr_err, "R9 per-bit clear", {ctx_err, addr_err}, 2'b10);

        // R6: init clears context and flags, keeps key
        pulse(1'b1);
        chk(ctx_flat == '0 && !ctx_err && !addr_err, "R6 init clears",
            {ctx_flat[63:0], ctx_err, addr_err}, '0);
        chk(key_out[63:0] == lo_key, "R6 init keeps key", key_out[63:0], lo_key);
        bus_wr(8'h20, 64'h4444);       // tracker cleared by init: accepted
        bus_rd(8'h20, rd);
        chk(rd == 64'h4444, "R6 tracker cleared by init", rd, 64'h4444);

        // R6: soft reset clears key and nonce too
        pulse(1'b0);
        mode_f9 = 1'b1;
        #1 chk(key_out == '0 && core_fresh == '0 && ctx_flat == '0, "R6 soft reset",
               {key_out[63:0], core_fresh}, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule